// File: doc/BRIEF.md
# Segmented-Carry Program Counter

This block holds a 16-bit instruction address and updates it on every clock edge. It loads one of two values: the address after the current one, for straight-line flow, or a value taken from the datapath result bus, for a jump. The current address goes to instruction fetch. The incremented address goes back to the datapath in the same cycle, so a call can store its return address while the jump target is being written.

The incrementer keeps its worst-case path short and fixed. Bit 0 of the next address is always the complement of the current bit 0, because the carry into the incrementer is tied high. Each higher bit either keeps its value or flips, depending on the carry that reaches it. The carry ripples only inside five 3-bit segments, which cover bits 1–3, 4–6, 7–9, 10–12 and 13–15. Current bit 0 is the carry into the lowest segment, and each segment's carry-out feeds the segment above it.

The carry out of the top segment is brought out directly. It also drives a small two-state machine:

- `WRAP_IDLE` moves to `WRAP_SEEN` when the counter steps sequentially from 0xFFFF.
- `WRAP_SEEN` stays where it is until reset.
- Reset returns the machine to `WRAP_IDLE`.

The sticky `wrap_err` output is high in `WRAP_SEEN`.

Top module: `pcseg_pc`

## Requirements
- R1: A synchronous active-high `rst`, sampled at a rising edge, makes `pc_q` 0x0000 and `wrap_err` 0 after that edge, whatever the other inputs are.
- R2: `pc_inc[0]` is always the complement of `pc_q[0]`.
- R3: `pc_inc` equals `pc_q + 1` modulo 2^16 in the same cycle, for every one of the 65536 values of `pc_q`.
- R4: When `ld_jump` is 1 at a rising edge (with `rst` 0), `pc_q` takes the value of `result_bus` after that edge.
- R5: When `ld_jump` is 0 at a rising edge (with `rst` 0), `pc_q` takes the value `pc_inc` had before that edge.
- R6: A sequential step (`ld_jump` 0) taken while `pc_q` is 0xFFFF makes `pc_q` 0x0000 and `wrap_err` 1 after that edge.
- R7: Once set, `wrap_err` stays 1 through any number of jumps and steps until a reset.
- R8: A jump (`ld_jump` 1) taken while `pc_q` is 0xFFFF leaves `wrap_err` unchanged.
- R9: `seg_ovf`, the carry out of the top segment, is 1 exactly when `pc_q` is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_jump | input | 1 | 1 selects `result_bus` as the next address, 0 selects the incremented address |
| result_bus | input | 16 | Jump target from the datapath result bus |
| pc_q | output | 16 | Current instruction address, to instruction fetch |
| pc_inc | output | 16 | Current address plus one, to the datapath |
| seg_ovf | output | 1 | Carry out of the top incrementer segment |
| wrap_err | output | 1 | Sticky flag: the counter has wrapped past 0xFFFF |

## Verification
`pc_q` and `wrap_err` are registered, so they are due one rising edge after `rst`, `ld_jump` and `result_bus` are presented. `pc_inc` and `seg_ovf` are combinational from `pc_q` and are valid in the same cycle as the address they belong to. The bench drives the inputs just after a falling edge and samples all four outputs at the next falling edge. By then exactly one rising edge has passed, and the reference model has been advanced by exactly one step. The full 16-bit input space of the incrementer is covered by jumping to every address in turn and reading `pc_inc` in the following cycle.

// File: rtl/pcseg_pkg.sv
package pcseg_pkg;
    localparam int PC_W  = 16;
    localparam int SEG_W = 3;

    typedef enum logic [0:0] {
        WRAP_IDLE = 1'b0,
        WRAP_SEEN = 1'b1
    } wrap_state_e;
endpackage

// File: rtl/pcseg_segment.sv
// One ripple segment: each bit keeps or flips according to its incoming carry.
module pcseg_segment #(
    parameter int SEG_W = 3
) (
    input  logic [SEG_W-1:0] bits_q,
    input  logic             carry_in,
    output logic [SEG_W-1:0] bits_inc,
    output logic             carry_out
);
    logic [SEG_W:0] chain;

    assign chain[0] = carry_in;

    generate
        for (genvar i = 0; i < SEG_W; i++) begin : g_bit
            assign bits_inc[i] = chain[i] ? ~bits_q[i] : bits_q[i];
            assign chain[i+1]  = chain[i] & bits_q[i];
        end
    endgenerate

    assign carry_out = chain[SEG_W];
endmodule

// File: rtl/pcseg_incr.sv
// Incrementer: toggling bit 0 followed by a cascade of short ripple segments.
module pcseg_incr #(
    parameter int PC_W  = 16,
    parameter int SEG_W = 3
) (
    input  logic [PC_W-1:0] cur,
    output logic [PC_W-1:0] nxt,
    output logic            top_carry
);
    localparam int NSEG = (PC_W - 1) / SEG_W;

    logic [NSEG:0] seg_carry;

    // Carry-in to the whole incrementer is fixed at 1, so bit 0 always flips
    // and the carry into bit 1 is simply the current bit 0.
    assign nxt[0]       = ~cur[0];
    assign seg_carry[0] = cur[0];

    generate
        for (genvar s = 0; s < NSEG; s++) begin : g_seg
            pcseg_segment #(.SEG_W(SEG_W)) u_seg (
                .bits_q   (cur[1 + s*SEG_W +: SEG_W]),
                .carry_in (seg_carry[s]),
                .bits_inc (nxt[1 + s*SEG_W +: SEG_W]),
                .carry_out(seg_carry[s+1])
            );
        end
    endgenerate

    assign top_carry = seg_carry[NSEG];
endmodule

// File: rtl/pcseg_pc.sv
module pcseg_pc
    import pcseg_pkg::*;
#(
    parameter int ADDR_W   = PC_W,
    parameter int CHUNK_W  = SEG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_jump,
    input  logic [ADDR_W-1:0] result_bus,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] pc_inc,
    output logic              seg_ovf,
    output logic              wrap_err
);
    wrap_state_e       state_q;
    wrap_state_e       state_d;
    logic [ADDR_W-1:0] pc_d;
    logic              carry_top;

    pcseg_incr #(.PC_W(ADDR_W), .SEG_W(CHUNK_W)) u_incr (
        .cur      (pc_q),
        .nxt      (pc_inc),
        .top_carry(carry_top)
    );

    assign seg_ovf = carry_top;

    // Source select in front of the address register.
    assign pc_d = ld_jump ? result_bus : pc_inc;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WRAP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WRAP_IDLE: if (carry_top && !ld_jump) state_d = WRAP_SEEN;
            WRAP_SEEN: state_d = WRAP_SEEN;
            default:   state_d = WRAP_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            WRAP_IDLE: wrap_err = 1'b0;
            WRAP_SEEN: wrap_err = 1'b1;
            default:   wrap_err = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcseg_pc_chk.sv
module pcseg_pc_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ld_jump,
    input logic [ADDR_W-1:0] result_bus,
    input logic [ADDR_W-1:0] pc_q,
    input logic [ADDR_W-1:0] pc_inc,
    input logic              seg_ovf,
    input logic              wrap_err
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pc_q == '0) && !wrap_err);

    // R2
    bit0_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        pc_inc[0] != pc_q[0]);

    // R4
    jump_load_chk: assert property (@(posedge clk) disable iff (rst)
        ld_jump |=> pc_q == $past(result_bus));

    // R5
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_jump |=> pc_q == $past(pc_q) + 1'b1);

    // R6
    wrap_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_jump && (pc_q == '1)) |=> wrap_err && (pc_q == '0));

    // R7
    sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_err |=> wrap_err);

    // R8
    jump_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_jump && !wrap_err) |=> !wrap_err);

    // R9
    top_carry_chk: assert property (@(posedge clk) disable iff (rst)
        seg_ovf == (pc_q == '1));
endmodule

bind pcseg_pc pcseg_pc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ld_jump   (ld_jump),
    .result_bus(result_bus),
    .pc_q      (pc_q),
    .pc_inc    (pc_inc),
    .seg_ovf   (seg_ovf),
    .wrap_err  (wrap_err)
);

// File: tb/pcseg_pc_tb.sv
module pcseg_pc_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_jump = 1'b0;
    logic [15:0] result_bus = '0;
    logic [15:0] pc_q;
    logic [15:0] pc_inc;
    logic        seg_ovf;
    logic        wrap_err;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_pc  = '0;
    logic        m_err = 1'b0;

    always #2 clk = ~clk;

    pcseg_pc u_dut (
        .clk(clk), .rst(rst), .ld_jump(ld_jump), .result_bus(result_bus),
        .pc_q(pc_q), .pc_inc(pc_inc), .seg_ovf(seg_ovf), .wrap_err(wrap_err)
    );

    function automatic logic [15:0] plus_one(input logic [15:0] v);
        return v + 16'd1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic verify(input string req);
        chk(pc_q === m_pc, {req, " pc_q"}, {16'd0, pc_q}, {16'd0, m_pc});
        // R3 R2: incremented value against a plain +1
        chk(pc_inc === plus_one(m_pc), {req, "/R3 pc_inc"}, {16'd0, pc_inc}, {16'd0, plus_one(m_pc)});
        // R9
        chk(seg_ovf === (m_pc == 16'hFFFF), {req, "/R9 seg_ovf"}, {31'd0, seg_ovf}, {31'd0, m_pc == 16'hFFFF});
        chk(wrap_err === m_err, {req, " wrap_err"}, {31'd0, wrap_err}, {31'd0, m_err});
    endtask

    // Drive just after a falling edge, advance the model, sample at the next falling edge.
    task automatic cycle(input logic r, input logic l, input logic [15:0] d, input string req);
        rst = r; ld_jump = l; result_bus = d;
        if (r) begin
            m_pc = '0; m_err = 1'b0;
        end else if (l) begin
            m_pc = d;
        end else begin
            if (m_pc == 16'hFFFF) m_err = 1'b1;
            m_pc = plus_one(m_pc);
        end
        @(negedge clk);
        verify(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20170417));
        @(negedge clk);
        cycle(1'b1, 1'b1, 16'hA5A5, "R1");
        chk(pc_inc[0] === ~pc_q[0], "R2 bit0", {31'd0, pc_inc[0]}, {31'd0, ~pc_q[0]});
        // R5: plain stepping from zero
        for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0, 16'hFFFF, "R5");
        // R3 R4: every address, reached by a jump
        for (int v = 0; v < 65536; v++) cycle(1'b0, 1'b1, v[15:0], "R4");
        // R8: jump while at 0xFFFF leaves the flag clear
        cycle(1'b0, 1'b1, 16'hFFFE, "R4");
        cycle(1'b0, 1'b0, 16'h0000, "R5");
        cycle(1'b0, 1'b1, 16'h1234, "R8");
        chk(wrap_err === 1'b0, "R8 flag", {31'd0, wrap_err}, 32'd0);
        // R6: sequential step from 0xFFFF wraps and sets the flag
        cycle(1'b0, 1'b1, 16'hFFFF, "R4");
        cycle(1'b0, 1'b0, 16'h0000, "R6");
        chk(wrap_err === 1'b1 && pc_q === 16'h0000, "R6 wrap", {15'd0, wrap_err, pc_q}, {15'd0, 1'b1, 16'h0000});
        // R7: flag holds through jumps and steps
        cycle(1'b0, 1'b1, 16'h0777, "R7");
        cycle(1'b0, 1'b0, 16'h0000, "R7");
        cycle(1'b0, 1'b1, 16'hFFFF, "R7");
        cycle(1'b0, 1'b0, 16'h0000, "R7");
        chk(wrap_err === 1'b1, "R7 sticky", {31'd0, wrap_err}, 32'd1);
        // R1: reset clears the flag
        cycle(1'b1, 1'b0, 16'h0000, "R1");
        chk(wrap_err === 1'b0 && pc_q === 16'h0000, "R1 clear", {15'd0, wrap_err, pc_q}, 32'd0);
        // Random mix of steps, jumps near the top, and rare resets
        for (int i = 0; i < 4000; i++) begin
            int unsigned p = $urandom_range(99);
            int unsigned q = $urandom_range(3);
            logic [15:0] d = (q == 0) ? 16'hFFFF - 16'($urandom_range(3)) : 16'($urandom);
            if (p < 3)       cycle(1'b1, 1'($urandom_range(1)), d, "R1");
            else if (p < 35) cycle(1'b0, 1'b1, d, "R4");
            else             cycle(1'b0, 1'b0, d, "R5");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule